// File: doc/BRIEF.md
# Boolean Register Branch Resolver

This block keeps a small file of one-bit condition registers for an in-order pipeline with fetch, register-read, execute/memory and write-back stages. A compare in the execute stage takes the single true/false verdict produced by a relational unit and writes it into the condition register it names. A conditional branch in the register-read stage names one condition register and a polarity. The block picks that bit and decides whether the branch is taken. It then chooses between the sequential and the target fetch address before the end of the same cycle. The branch therefore resolves at the end of register read and leaves one delay slot.

Conditions can be computed well ahead of their branches and held for as long as needed. The whole file can also be read as one packed byte for a store, and written from a packed byte by a load retiring in write-back. A compare and a load that write in the same cycle as a branch or store reads are forwarded to that reader. Where both write the same register, the younger compare has priority over the older load.

Top module: `boolbr_resolver`

## Requirements
- R1: After reset every condition register is false, so the packed view `st_byte` reads all zeros.
- R2: When `cmp_wr_en` is high, register `cmp_wr_idx` takes `cmp_result` at the clock edge. All other registers keep their values unless a load writes them.
- R3: When `ld_wr_en` is high, register k takes `ld_byte[k]` at the clock edge for every k. A compare writing the same register in the same cycle wins for that one bit.
- R4: `st_byte[k]` shows condition register k, with bit k holding register k. The same-cycle compare and load writes are forwarded into it with the priority of R3.
- R5: `br_taken` is high exactly when `br_valid` is high and the selected register equals `br_sense`. `br_sense` 1 is branch-if-true and 0 is branch-if-false.
- R6: `next_pc` equals `tgt_pc` when `br_taken` is high and `seq_pc` otherwise, in the same cycle as the branch is presented.
- R7: A compare writing register `br_idx` in the same cycle as a branch reads it is forwarded, so the branch sees `cmp_result`.
- R8: A load writing in the same cycle as a branch reads is forwarded to the branch when no compare writes that register in that cycle.
- R9: With no compare or load, every register holds its value indefinitely, so conditions may be computed many cycles before their branch.
- R10: With `br_valid` low, `br_taken` is low and `next_pc` equals `seq_pc`, whatever the registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_wr_en | input | 1 | Compare in execute stage writes a condition register |
| cmp_wr_idx | input | IDX_W | Destination register of the compare |
| cmp_result | input | 1 | Verdict from the relational unit |
| ld_wr_en | input | 1 | Load of the packed condition byte retiring in write-back |
| ld_byte | input | NUM_BREGS | Packed value loaded, bit k for register k |
| br_valid | input | 1 | Conditional branch present in register-read stage |
| br_idx | input | IDX_W | Condition register the branch tests |
| br_sense | input | 1 | 1 = branch if true, 0 = branch if false |
| seq_pc | input | PC_W | Sequential fetch address |
| tgt_pc | input | PC_W | Branch target address from the target adder |
| st_byte | output | NUM_BREGS | Packed condition registers for a store, forwarded |
| br_taken | output | 1 | Branch resolved taken |
| next_pc | output | PC_W | Selected next fetch address |

## Verification
A corrupted condition register stays hidden until something reads it. It shows up on `st_byte` in the first cycle after the bad write, and on `br_taken` and `next_pc` as soon as a branch names that register. The bench reads the packed byte every cycle to catch wrong state at once. Many branches test each index under both polarities, with and without same-cycle writes, so that a bad forward or priority shows up within the cycle it happens.

// File: rtl/boolbr_pkg.sv
package boolbr_pkg;
   typedef enum logic {
      SENSE_FALSE = 1'b0,
      SENSE_TRUE  = 1'b1
   } br_sense_e;

   typedef enum int {
      SEL_MUX_TREE = 0,
      SEL_ONE_HOT  = 1
   } sel_style_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/bool_regfile.sv
module bool_regfile #(
   parameter int NUM_BREGS = 8,
   localparam int IDX_W = $clog2(NUM_BREGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmp_en,
   input  logic [IDX_W-1:0]     cmp_idx,
   input  logic                 cmp_val,
   input  logic                 ld_en,
   input  logic [NUM_BREGS-1:0] ld_val,
   output logic [NUM_BREGS-1:0] q
);
   for (genvar k = 0; k < NUM_BREGS; k++) begin : g_bit
      logic hit;
      assign hit = cmp_en && (cmp_idx == IDX_W'(k));
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[k] <= 1'b0;
         else if (hit)
            q[k] <= cmp_val;
         else if (ld_en)
            q[k] <= ld_val[k];
      end
   end
endmodule

// File: rtl/bool_bypass.sv
module bool_bypass #(
   parameter int NUM_BREGS = 8,
   localparam int IDX_W = $clog2(NUM_BREGS)
) (
   input  logic [NUM_BREGS-1:0] q,
   input  logic                 cmp_en,
   input  logic [IDX_W-1:0]     cmp_idx,
   input  logic                 cmp_val,
   input  logic                 ld_en,
   input  logic [NUM_BREGS-1:0] ld_val,
   output logic [NUM_BREGS-1:0] view
);
   for (genvar k = 0; k < NUM_BREGS; k++) begin : g_bit
      always_comb begin
         if (cmp_en && (cmp_idx == IDX_W'(k)))
            view[k] = cmp_val;
         else if (ld_en)
            view[k] = ld_val[k];
         else
            view[k] = q[k];
      end
   end
endmodule

// File: rtl/bool_select.sv
module bool_select #(
   parameter int NUM_BREGS = 8,
   parameter int SEL_STYLE = 0,
   localparam int IDX_W = $clog2(NUM_BREGS)
) (
   input  logic [NUM_BREGS-1:0] view,
   input  logic [IDX_W-1:0]     idx,
   output logic                 bit_out
);
   if (SEL_STYLE == boolbr_pkg::SEL_ONE_HOT) begin : g_onehot
      logic [NUM_BREGS-1:0] dec;
      for (genvar k = 0; k < NUM_BREGS; k++) begin : g_dec
         assign dec[k] = (idx == IDX_W'(k));
      end
      assign bit_out = |(dec & view);
   end else begin : g_tree
      for (genvar l = 0; l < IDX_W; l++) begin : g_lvl
         localparam int W = NUM_BREGS >> (l + 1);
         logic [W-1:0] node;
         for (genvar j = 0; j < W; j++) begin : g_node
            if (l == 0) begin : g_leaf
               assign node[j] = idx[0] ? view[2*j+1] : view[2*j];
            end else begin : g_inner
               assign node[j] = idx[l] ? g_lvl[l-1].node[2*j+1]
                                       : g_lvl[l-1].node[2*j];
            end
         end
      end
      assign bit_out = g_lvl[IDX_W-1].node[0];
   end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve #(
   parameter int PC_W = 32
) (
   input  logic            cond_bit,
   input  logic            br_valid,
   input  logic            br_sense,
   input  logic [PC_W-1:0] seq_pc,
   input  logic [PC_W-1:0] tgt_pc,
   output logic            br_taken,
   output logic [PC_W-1:0] next_pc
);
   always_comb begin
      br_taken = br_valid && (cond_bit == br_sense);
      next_pc  = br_taken ? tgt_pc : seq_pc;
   end
endmodule

// File: rtl/boolbr_resolver.sv
module boolbr_resolver #(
   parameter int NUM_BREGS = 8,
   parameter int PC_W      = 32,
   parameter int SEL_STYLE = 0,
   localparam int IDX_W = $clog2(NUM_BREGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmp_wr_en,
   input  logic [IDX_W-1:0]     cmp_wr_idx,
   input  logic                 cmp_result,
   input  logic                 ld_wr_en,
   input  logic [NUM_BREGS-1:0] ld_byte,
   input  logic                 br_valid,
   input  logic [IDX_W-1:0]     br_idx,
   input  logic                 br_sense,
   input  logic [PC_W-1:0]      seq_pc,
   input  logic [PC_W-1:0]      tgt_pc,
   output logic [NUM_BREGS-1:0] st_byte,
   output logic                 br_taken,
   output logic [PC_W-1:0]      next_pc
);
   if (!boolbr_pkg::is_pow2(NUM_BREGS)) begin : g_bad_count
      $error("NUM_BREGS must be a power of two of at least 2");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("PC_W must be at least 2");
   end
   if (SEL_STYLE != boolbr_pkg::SEL_MUX_TREE &&
       SEL_STYLE != boolbr_pkg::SEL_ONE_HOT) begin : g_bad_style
      $error("SEL_STYLE must be 0 (mux tree) or 1 (one-hot)");
   end

   logic [NUM_BREGS-1:0] regs_q;
   logic [NUM_BREGS-1:0] fwd_view;
   logic                 sel_bit;

   bool_regfile #(.NUM_BREGS(NUM_BREGS)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmp_en (cmp_wr_en),
      .cmp_idx(cmp_wr_idx),
      .cmp_val(cmp_result),
      .ld_en  (ld_wr_en),
      .ld_val (ld_byte),
      .q      (regs_q)
   );

   bool_bypass #(.NUM_BREGS(NUM_BREGS)) u_bypass (
      .q      (regs_q),
      .cmp_en (cmp_wr_en),
      .cmp_idx(cmp_wr_idx),
      .cmp_val(cmp_result),
      .ld_en  (ld_wr_en),
      .ld_val (ld_byte),
      .view   (fwd_view)
   );

   bool_select #(.NUM_BREGS(NUM_BREGS), .SEL_STYLE(SEL_STYLE)) u_sel (
      .view   (fwd_view),
      .idx    (br_idx),
      .bit_out(sel_bit)
   );

   branch_resolve #(.PC_W(PC_W)) u_resolve (
      .cond_bit(sel_bit),
      .br_valid(br_valid),
      .br_sense(br_sense),
      .seq_pc  (seq_pc),
      .tgt_pc  (tgt_pc),
      .br_taken(br_taken),
      .next_pc (next_pc)
   );

   assign st_byte = fwd_view;
endmodule

// File: rtl/boolbr_resolver_chk.sv
module boolbr_resolver_chk #(
   parameter int NUM_BREGS = 8,
   parameter int PC_W      = 32,
   localparam int IDX_W = $clog2(NUM_BREGS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmp_wr_en,
   input logic [IDX_W-1:0]     cmp_wr_idx,
   input logic                 cmp_result,
   input logic                 ld_wr_en,
   input logic [NUM_BREGS-1:0] ld_byte,
   input logic                 br_valid,
   input logic [IDX_W-1:0]     br_idx,
   input logic                 br_sense,
   input logic [PC_W-1:0]      seq_pc,
   input logic [PC_W-1:0]      tgt_pc,
   input logic [NUM_BREGS-1:0] st_byte,
   input logic                 br_taken,
   input logic [PC_W-1:0]      next_pc
);
   // R10
   idle_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |-> (!br_taken && next_pc == seq_pc));

   // R6
   taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> next_pc == tgt_pc);

   // R7
   cmp_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && cmp_wr_en && cmp_wr_idx == br_idx)
         |-> br_taken == (cmp_result == br_sense));

   // R4
   store_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr_en |-> st_byte[cmp_wr_idx] == cmp_result);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_wr_en && !ld_wr_en) |=> (cmp_wr_en || ld_wr_en || $stable(st_byte)));

   // R5
   branch_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !cmp_wr_en && !ld_wr_en)
         |-> br_taken == (st_byte[br_idx] == br_sense));
endmodule

bind boolbr_resolver boolbr_resolver_chk #(
   .NUM_BREGS(NUM_BREGS),
   .PC_W     (PC_W)
) chk_i (.*);

// File: tb/boolbr_resolver_test.sv
module boolbr_resolver_test;
   localparam int N  = 8;
   localparam int IW = 3;
   localparam int PW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_wr_en = 1'b0;
   logic [IW-1:0] cmp_wr_idx = '0;
   logic          cmp_result = 1'b0;
   logic          ld_wr_en = 1'b0;
   logic [N-1:0]  ld_byte = '0;
   logic          br_valid = 1'b0;
   logic [IW-1:0] br_idx = '0;
   logic          br_sense = 1'b0;
   logic [PW-1:0] seq_pc = '0;
   logic [PW-1:0] tgt_pc = '0;
   logic [N-1:0]  st_byte;
   logic          br_taken;
   logic [PW-1:0] next_pc;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] mreg = '0;
   logic [31:0]  lcg = 32'h1234_5678;
   bit           after_reset = 1'b0;
   bit           done = 1'b0;

   always #2.5 clk = ~clk;

   boolbr_resolver #(.NUM_BREGS(N), .PC_W(PW)) uut (.*);

   function automatic logic [31:0] rnd();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   task automatic check(input string tag, input logic [PW-1:0] act,
                        input logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // drive at negedge, check 1 ns later, update model at posedge
   task automatic step(input bit ce, input int ci, input bit cv,
                       input bit le, input logic [N-1:0] lb,
                       input bit bv, input int bi, input bit bs);
      logic [N-1:0] ev;
      logic         eb, et;
      string        btag, stag;
      cmp_wr_en = ce; cmp_wr_idx = IW'(ci); cmp_result = cv;
      ld_wr_en = le; ld_byte = lb;
      br_valid = bv; br_idx = IW'(bi); br_sense = bs;
      seq_pc = rnd(); tgt_pc = rnd();
      #1;
      for (int k = 0; k < N; k++)
         ev[k] = (ce && ci == k) ? cv : (le ? lb[k] : mreg[k]);
      eb = ev[bi];
      et = bv && (eb == bs);
      if (!bv) btag = "R10";
      else if (ce && ci == bi) btag = "R7";
      else if (le) btag = "R8";
      else btag = "R5";
      if (after_reset && !ce && !le) stag = "R1";
      else if (ce || le) stag = "R4";
      else stag = "R9";
      check(btag, PW'(br_taken), PW'(et));
      check("R6", next_pc, et ? tgt_pc : seq_pc);
      check(stag, PW'(st_byte), PW'(ev));
      after_reset = 1'b0;
      @(posedge clk);
      for (int k = 0; k < N; k++)
         if (ce && ci == k) mreg[k] = cv;
         else if (le) mreg[k] = lb[k];
      @(negedge clk);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, '0, 0, 0, 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mreg = '0;
      after_reset = 1'b1;
      // R1: reset state, then branch-if-false on a cleared register is taken
      step(0, 0, 0, 0, '0, 1, 5, 0);
      // R2: write alternating pattern by compares, one at a time
      for (int k = 0; k < N; k++) step(1, k, k[0], 0, '0, 0, 0, 0);
      // R9: long hold, then branch every index both senses
      for (int c = 0; c < 40; c++) idle();
      for (int k = 0; k < N; k++) begin
         step(0, 0, 0, 0, '0, 1, k, 1);
         step(0, 0, 0, 0, '0, 1, k, 0);
      end
      // R10: branch slot empty
      step(0, 0, 0, 0, '0, 0, 1, 1);
      // R7: compare forwarded to same-cycle branch, both results
      step(1, 3, 0, 0, '0, 1, 3, 1);
      step(1, 3, 1, 0, '0, 1, 3, 1);
      step(1, 2, 1, 0, '0, 1, 6, 0);
      // R3: load byte, and load with compare to same register (compare wins)
      step(0, 0, 0, 1, 8'hA5, 0, 0, 0);
      idle();
      step(1, 0, 0, 1, 8'hFF, 0, 0, 0);
      idle();
      // R8: load forwarded to branch
      step(0, 0, 0, 1, 8'h10, 1, 4, 1);
      step(1, 4, 0, 1, 8'h10, 1, 4, 1);
      idle();
      // mixed random traffic
      for (int c = 0; c < 400; c++) begin
         logic [31:0] r;
         r = rnd();
         step(r[0], int'(r[3:1]), r[4], r[5] & r[6] & r[7], r[15:8],
              r[16] | r[17], int'(r[20:18]), r[21]);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule